// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a 32-bit signed position for rotary encoders, thumbwheels and plain up/down pulse sources. Two track inputs feed a decoder that runs in one of four modes. The first mode reads Gray-coded quadrature. The second reads a 2-bit binary code. The third counts rising edges of one track, and the level of the other track sets the direction. The fourth counts up on edges of one track and down on edges of the other. A third input serves as an index mark or push-button. Each of the three inputs passes through a two-flop synchronizer and then a debounce filter whose settling time is set by a configuration field.

Two signed limits guard the position. When a count step would move past a limit, the block raises a one-cycle interrupt pulse. It then either keeps the new value or, in auto-zero mode, loads zero. On every applied step the block emits a one-cycle event strobe, which a separate timer can use to measure the spacing between counts. All settings arrive as static configuration inputs.

Top module: `qcnt_top`

## Requirements
- R1: While `rst_n` is low and after its release, `count` is 0 and every pulse output (`cnt_evt`, `err_irq`, `hi_irq`, `lo_irq`, `zm_evt`) is low, until a filtered input changes.
- R2: With `cfg_mode`=0 (Gray), the filtered pair {a,b} stepping 00→01→11→10→00 adds 1 per step, and the reverse order subtracts 1 per step.
- R3: In Gray mode (`cfg_mode`=0) or binary mode (`cfg_mode`=1), a transition that jumps two code positions leaves `count` unchanged and pulses `err_irq` for one cycle.
- R4: With `cfg_mode`=1 (binary), {a,b} is read as an unsigned 2-bit value (a is the MSB). A change of +1 modulo 4 counts up, and a change of −1 modulo 4 counts down.
- R5: With `cfg_mode`=2, each rising edge of filtered a counts up when filtered b is 1 and down when b is 0. Changes of b alone do not count.
- R6: With `cfg_mode`=3, a rising edge of filtered a counts up and a rising edge of filtered b counts down. When both rise together, nothing changes.
- R7: The filtered level of each input follows the pin only after the two-flop synchronized pin has differed from it for 2^`cfg_flt` consecutive clocks. Shorter pulses are ignored.
- R8: A rising edge of the filtered index input pulses `zm_evt`. If `cfg_zclr` is 1, it also loads `count` with 0 and suppresses any step in that cycle. If `cfg_zclr` is 0, `count` is unaffected.
- R9: A step whose result is greater than signed `cfg_hi` pulses `hi_irq`. `count` then becomes 0 when `cfg_auto` is 1, and takes the result when `cfg_auto` is 0.
- R10: A step whose result is less than signed `cfg_lo` pulses `lo_irq`. `count` then becomes 0 when `cfg_auto` is 1, and takes the result when `cfg_auto` is 0.
- R11: `cnt_evt` is high for exactly one cycle in the same cycle that each applied step updates `count`. `count` holds when no step or index clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Track A pin (asynchronous) |
| enc_b | input | 1 | Track B pin (asynchronous) |
| enc_z | input | 1 | Index / push-button pin (asynchronous) |
| cfg_mode | input | 2 | 0 Gray, 1 binary, 2 direction-level, 3 two-edge |
| cfg_flt | input | 4 | Debounce exponent N, settling time 2^N clocks |
| cfg_zclr | input | 1 | Index edge clears the position |
| cfg_auto | input | 1 | Limit crossing loads zero instead of the result |
| cfg_hi | input | 32 | Signed upper limit |
| cfg_lo | input | 32 | Signed lower limit |
| count | output | 32 | Signed position |
| cnt_evt | output | 1 | One-cycle strobe per applied step |
| err_irq | output | 1 | One-cycle pulse on an illegal code jump |
| hi_irq | output | 1 | One-cycle pulse on upper-limit crossing |
| lo_irq | output | 1 | One-cycle pulse on lower-limit crossing |
| zm_evt | output | 1 | One-cycle pulse on index rising edge |

## Verification
A wrong stored previous code in the decoder shows on the very next filtered transition. It appears either as a count in the wrong direction or as a false `err_irq`, and the position then stays off by that amount for good, so every later read of `count` exposes it. A debounce counter that miscounts moves the time `count` changes by one or more cycles, and it can let a short glitch through. This is caught by sampling just before and just after the 2^N window. Errors in the limit logic show in the same cycle as the offending step, as a missing interrupt pulse or a non-zero position in auto-zero mode.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [1:0] {
    QM_GRAY = 2'd0,
    QM_BIN  = 2'd1,
    QM_DIR  = 2'd2,
    QM_EDGE = 2'd3
  } qmode_e;
endpackage

// File: rtl/qcnt_debounce.sv
module qcnt_debounce #(
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [FLT_W-1:0] sel,
  output logic             flt
);
  localparam int CNT_W = 1 << FLT_W;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]       run_q, run_d, lim;
  logic                   flt_q, flt_d, sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    lim    = ({{(CNT_W-1){1'b0}}, 1'b1} << sel) - {{(CNT_W-1){1'b0}}, 1'b1};
    flt_d  = flt_q;
    run_d  = run_q;
    if (sync_last == flt_q) begin
      run_d = '0;
    end else if (run_q == lim) begin
      flt_d = sync_last;
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      flt_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      run_q  <= run_d;
      flt_q  <= flt_d;
    end
  end

  assign flt = flt_q;

  // R7: filtered level cannot move while the synchronized pin agrees with it
  assert_flt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_last == flt_q) |=> $stable(flt_q));
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
  import qcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   a,
  input  logic   b,
  output logic   step_up,
  output logic   step_dn,
  output logic   bad
);
  logic       pa_q, pb_q;
  logic [1:0] old_v, new_v, diff;
  logic       rise_a, rise_b;

  always_comb begin
    if (mode == QM_GRAY) begin
      old_v = {pa_q, pa_q ^ pb_q};
      new_v = {a, a ^ b};
    end else begin
      old_v = {pa_q, pb_q};
      new_v = {a, b};
    end
    diff   = new_v - old_v;
    rise_a = a & ~pa_q;
    rise_b = b & ~pb_q;
    step_up = 1'b0;
    step_dn = 1'b0;
    bad     = 1'b0;
    case (mode)
      QM_GRAY, QM_BIN: begin
        step_up = (diff == 2'd1);
        step_dn = (diff == 2'd3);
        bad     = (diff == 2'd2);
      end
      QM_DIR: begin
        step_up = rise_a & b;
        step_dn = rise_a & ~b;
      end
      default: begin
        step_up = rise_a & ~rise_b;
        step_dn = rise_b & ~rise_a;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= a;
      pb_q <= b;
    end
  end

  // R2: a decode cycle yields at most one of up, down, illegal
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, bad}));
endmodule

// File: rtl/qcnt_top.sv
module qcnt_top
  import qcnt_pkg::*;
#(
  parameter int CW    = 32,
  parameter int FLT_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_z,
  input  logic [1:0]    cfg_mode,
  input  logic [FLT_W-1:0] cfg_flt,
  input  logic          cfg_zclr,
  input  logic          cfg_auto,
  input  logic [CW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_lo,
  output logic [CW-1:0] count,
  output logic          cnt_evt,
  output logic          err_irq,
  output logic          hi_irq,
  output logic          lo_irq,
  output logic          zm_evt
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_raw, pin_flt;
  logic            up, dn, bad, zp_q, zfire, zclr, step, over, under;
  logic [CW-1:0]   count_q, count_d, cand;
  logic            evt_d, evt_q, err_q, hi_d, hi_q, lo_d, lo_q, zm_q;

  assign pin_raw = {enc_z, enc_b, enc_a};

  for (genvar i = 0; i < NPIN; i++) begin : g_flt
    qcnt_debounce #(.FLT_W(FLT_W), .SYNC_STAGES(2)) u_flt (
      .clk(clk), .rst_n(rst_n), .raw(pin_raw[i]), .sel(cfg_flt), .flt(pin_flt[i])
    );
  end

  qcnt_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(qmode_e'(cfg_mode)),
    .a(pin_flt[0]), .b(pin_flt[1]),
    .step_up(up), .step_dn(dn), .bad(bad)
  );

  always_comb begin
    zfire   = pin_flt[2] & ~zp_q;
    zclr    = zfire & cfg_zclr;
    step    = (up | dn) & ~zclr;
    cand    = up ? count_q + 1'b1 : count_q - 1'b1;
    over    = $signed(cand) > $signed(cfg_hi);
    under   = $signed(cand) < $signed(cfg_lo);
    evt_d   = step;
    hi_d    = step & over;
    lo_d    = step & under & ~over;
    count_d = count_q;
    if (zclr) begin
      count_d = '0;
    end else if (step) begin
      count_d = (cfg_auto && (over || under)) ? '0 : cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      zp_q    <= 1'b0;
      evt_q   <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      zm_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      zp_q    <= pin_flt[2];
      evt_q   <= evt_d;
      err_q   <= bad;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      zm_q    <= zfire;
    end
  end

  assign count   = count_q;
  assign cnt_evt = evt_q;
  assign err_irq = err_q;
  assign hi_irq  = hi_q;
  assign lo_irq  = lo_q;
  assign zm_evt  = zm_q;

  // R11: position holds without a step or index clear
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(up || dn) && !zclr) |=> $stable(count_q));

  // R3: an illegal jump never moves the position
  assert_err_nocount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !zclr) |=> $stable(count_q));

  // R9: auto-zero leaves the position at zero after an upper crossing
  assert_autozero_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q && $past(cfg_auto)) |-> (count_q == '0));

  // R10: auto-zero leaves the position at zero after a lower crossing
  assert_autozero_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q && $past(cfg_auto)) |-> (count_q == '0));

  // R8: an index clear produces no step strobe
  assert_zclr_noevt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zclr |=> !evt_q);
endmodule

// File: tb/tb_qcnt_top.sv
module tb_qcnt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_a, enc_b, enc_z;
  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_flt;
  logic        cfg_zclr, cfg_auto;
  logic [31:0] cfg_hi, cfg_lo;
  logic [31:0] count;
  logic        cnt_evt, err_irq, hi_irq, lo_irq, zm_evt;

  int n_chk = 0, n_bad = 0;
  int m_evt = 0, m_err = 0, m_hi = 0, m_lo = 0, m_zm = 0;
  int e_cnt = 0, e_evt = 0, e_err = 0, e_hi = 0, e_lo = 0, e_zm = 0;
  logic pa = 1'b0, pb = 1'b0;
  bit done = 1'b0;

  localparam int WAIT = 12;

  always #2 clk = ~clk;

  qcnt_top dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .cfg_mode(cfg_mode), .cfg_flt(cfg_flt), .cfg_zclr(cfg_zclr), .cfg_auto(cfg_auto),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .count(count), .cnt_evt(cnt_evt),
    .err_irq(err_irq), .hi_irq(hi_irq), .lo_irq(lo_irq), .zm_evt(zm_evt)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      m_evt <= m_evt + int'(cnt_evt);
      m_err <= m_err + int'(err_irq);
      m_hi  <= m_hi  + int'(hi_irq);
      m_lo  <= m_lo  + int'(lo_irq);
      m_zm  <= m_zm  + int'(zm_evt);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic int decode(logic [1:0] mode, logic oa, logic ob, logic na, logic nb);
    logic [1:0] ov, nv, d;
    if (mode <= 2'd1) begin
      ov = (mode == 2'd0) ? {oa, oa ^ ob} : {oa, ob};
      nv = (mode == 2'd0) ? {na, na ^ nb} : {na, nb};
      d  = nv - ov;
      return (d == 2'd1) ? 1 : (d == 2'd3) ? -1 : (d == 2'd2) ? 2 : 0;
    end else if (mode == 2'd2) begin
      return (na && !oa) ? (nb ? 1 : -1) : 0;
    end else begin
      if (na && !oa && !(nb && !ob)) return 1;
      if (nb && !ob && !(na && !oa)) return -1;
      return 0;
    end
  endfunction

  task automatic model(int code);
    int c;
    if (code == 2) begin
      e_err++;
    end else if (code != 0) begin
      c = e_cnt + code;
      e_evt++;
      if (c > $signed(cfg_hi)) begin
        e_hi++;
        if (cfg_auto) c = 0;
      end else if (c < $signed(cfg_lo)) begin
        e_lo++;
        if (cfg_auto) c = 0;
      end
      e_cnt = c;
    end
  endtask

  task automatic step(logic na, logic nb);
    @(negedge clk);
    enc_a = na;
    enc_b = nb;
    model(decode(cfg_mode, pa, pb, na, nb));
    pa = na;
    pb = nb;
    repeat (WAIT) @(negedge clk);
  endtask

  task automatic zpulse();
    @(negedge clk);
    enc_z = 1'b1;
    repeat (WAIT) @(negedge clk);
    enc_z = 1'b0;
    e_zm++;
    if (cfg_zclr) e_cnt = 0;
    repeat (WAIT) @(negedge clk);
  endtask

  task automatic cmp_all(string tag);
    check({tag, " count"}, $signed(count), e_cnt);
    check({tag, " evt"}, m_evt, e_evt);
    check({tag, " err"}, m_err, e_err);
    check({tag, " hi"}, m_hi, e_hi);
    check({tag, " lo"}, m_lo, e_lo);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_z = 1'b0;
    cfg_mode = 2'd0; cfg_flt = 4'd2; cfg_zclr = 1'b0; cfg_auto = 1'b0;
    cfg_hi = 32'd100000; cfg_lo = -32'sd100000;
    repeat (5) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    rst_n = 1'b1;
    repeat (WAIT) @(negedge clk);
    check("R1 count after reset", int'(count), 0);
    check("R1 pulses after reset", int'({cnt_evt, err_irq, hi_irq, lo_irq, zm_evt}), 0);

    // R2 Gray up and down
    step(0,1); step(1,1); step(1,0); step(0,0);
    cmp_all("R2 gray up");
    check("R11 evt per step", m_evt, 4);
    step(1,0); step(1,1); step(0,1); step(0,0); step(1,0);
    cmp_all("R2 gray down");

    // R3 illegal Gray jump from 10 to 01
    step(0,1);
    cmp_all("R3 gray illegal");
    step(0,0);

    // R4 binary
    cfg_mode = 2'd1;
    step(0,1); step(1,0); step(1,1); step(0,0); step(1,1);
    cmp_all("R4 binary");
    step(0,1);
    cmp_all("R3 binary jump");
    step(0,0);

    // R5 direction level
    cfg_mode = 2'd2;
    step(0,1); step(1,1); step(0,1); step(1,1); step(0,0); step(1,0); step(0,0);
    cmp_all("R5 direction");

    // R6 two-edge
    cfg_mode = 2'd3;
    step(1,0); step(0,0); step(0,1); step(0,0); step(0,1); step(0,0); step(1,1); step(0,0);
    cmp_all("R6 two-edge");

    // R7 debounce: 3-cycle glitch ignored, 4-cycle pulse accepted (N=2)
    @(negedge clk); enc_a = 1'b1;
    repeat (3) @(negedge clk); enc_a = 1'b0;
    repeat (WAIT) @(negedge clk);
    cmp_all("R7 short glitch");
    enc_a = 1'b1;
    repeat (4) @(negedge clk); enc_a = 1'b0;
    model(1);
    repeat (WAIT) @(negedge clk);
    cmp_all("R7 accepted pulse");
    // R7 exact latency with N=2: step applied 2+4+1 edges after the pin change
    step(0,1); step(0,0);
    @(negedge clk); enc_a = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 before window", $signed(count), e_cnt);
    @(negedge clk);
    check("R7 at window", $signed(count), e_cnt + 1);
    model(1); pa = 1'b1;
    repeat (WAIT) @(negedge clk);
    step(0,0);

    // R8 index
    zpulse();
    check("R8 index pulse", m_zm, e_zm);
    check("R8 no clear", $signed(count), e_cnt);
    cfg_zclr = 1'b1;
    zpulse();
    check("R8 index clear", $signed(count), 0);
    check("R8 index pulse 2", m_zm, e_zm);
    cfg_zclr = 1'b0;

    // R9 / R10 limits
    cfg_mode = 2'd3; cfg_hi = 32'd2; cfg_lo = -32'sd2;
    step(1,0); step(0,0); step(1,0); step(0,0); step(1,0); step(0,0);
    cmp_all("R9 hi no auto");
    cfg_auto = 1'b1;
    step(1,0); step(0,0);
    cmp_all("R9 hi auto zero");
    cfg_auto = 1'b0;
    step(0,1); step(0,0); step(0,1); step(0,0); step(0,1); step(0,0);
    cmp_all("R10 lo no auto");
    cfg_auto = 1'b1;
    step(0,1); step(0,0);
    cmp_all("R10 lo auto zero");
    cfg_auto = 1'b0;

    // random phase: R2 R3 R4 R5 R6 R11
    cfg_hi = 32'd40; cfg_lo = -32'sd40;
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        cfg_mode = 2'($urandom_range(3));
        cfg_auto = 1'($urandom_range(1));
      end
      step(1'($urandom_range(1)), 1'($urandom_range(1)));
      check("R11 random count", $signed(count), e_cnt);
    end
    cmp_all("R11 random totals");

    done = 1'b1;
    summary();
  end
endmodule